// File: doc/BRIEF.md
# Double-Length Accumulator Pair Shifter

This block shifts a 64-bit quantity made of two 32-bit registers right by one bit per clock. The upper half is the accumulator A and the lower half is the extension register R. On every step, the low bit of A moves into the top bit of R, and R moves right by one place. The top bit of A is then filled in one of two ways. In circular mode it takes the bit that fell out of the bottom of R, so the whole pair rotates. In arithmetic mode it keeps the sign of A.

The shift distance is not given directly. A 6-bit count c is loaded at start and incremented after each step, and shifting stops when it wraps back to zero. A start therefore performs 64 − c steps, and a count of zero gives a full 64 steps. While idle, a controller may load both registers in one cycle. It then issues start with the mode and count, and waits for the one-cycle done pulse before it reads A and R.

The control is a three-state machine:
- IDLE waits, accepts loads and leaves on start (transition GO).
- SHIFT performs one step per cycle. It stays there (transition STEP) until the counter is about to wrap (transition LAST).
- FINISH raises done for one cycle and returns to IDLE (transition RETIRE).

Top module: `pair_shifter`

## Requirements
- R1: After reset, A and R read zero, busy is low and done is low.
- R2: When load_en is high while busy is low, A takes load_a and R takes load_r at the next clock edge.
- R3: load_en is ignored while busy is high; A and R at done are those of an undisturbed shift.
- R4: Each step places the old A bit 0 in R bit 31 and moves R right by one bit (R bit i takes old R bit i+1).
- R5: With mode = 0 (circular), each step places the old R bit 0 in A bit 31 and moves the rest of A right by one bit, so the 64-bit pair keeps its number of ones.
- R6: With mode = 1 (arithmetic), each step keeps A bit 31 and moves A right by one bit, so the sign of A never changes during a run.
- R7: A start with count c performs exactly 64 − c steps; a count of 0 performs 64 steps.
- R8: If start is sampled high at edge E while idle, busy is high from E on, and done is high for exactly one cycle after edge E + (64 − c). After that edge busy and done are both low.
- R9: start is ignored while busy is high; mode and count are taken only at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a shift run (taken only when idle) |
| mode | input | 1 | 0 = circular rotate, 1 = arithmetic shift |
| count | input | 6 | Initial counter value c; the run makes 64 − c steps |
| load_en | input | 1 | Load A and R from load_a and load_r (only when idle) |
| load_a | input | 32 | Load value for A |
| load_r | input | 32 | Load value for R |
| acc_a | output | 32 | Current A |
| ext_r | output | 32 | Current R |
| busy | output | 1 | High from the accepting edge until the end of the done cycle |
| done | output | 1 | One-cycle pulse after the last step |

## Verification
The hardest case to reach is the 64-step run started with count zero. Its counter has to pass through every value and wrap exactly once, and in circular mode it returns the pair to its starting value, so a wrong step count could hide behind a correct result. The bench drives that case with asymmetric load patterns. It also counts the clock edges up to done for several counts, including the single-step count 63. Stray start and load pulses are raised in the middle of a run, and the bench then checks that the final pair equals an undisturbed reference.

// File: rtl/pair_shifter_pkg.sv
package pair_shifter_pkg;

    localparam int HALF_W = 32;
    localparam int CNT_W  = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } shift_state_t;

    typedef enum logic {
        MODE_ROTATE = 1'b0,
        MODE_ARITH  = 1'b1
    } shift_mode_t;

endpackage

// File: rtl/shift_step_counter.sv
module shift_step_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] init,
    input  logic             advance,
    output logic             last
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= init;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the step taken from the all-ones value wraps the counter to zero
    assign last = (cnt_q == TOP);
endmodule

// File: rtl/shift_control.sv
module shift_control
    import pair_shifter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last,
    output logic accept,
    output logic step_en,
    output logic busy,
    output logic done
);
    shift_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SHIFT;   // GO
            ST_SHIFT:  if (last)  state_d = ST_FINISH;  // LAST (else STEP)
            ST_FINISH: state_d = ST_IDLE;               // RETIRE
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = 1'b0;
        step_en = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_SHIFT:  step_en = 1'b1;
            ST_FINISH: done    = 1'b1;
            default:   busy    = 1'b0;
        endcase
    end
endmodule

// File: rtl/pair_datapath.sv
module pair_datapath
    import pair_shifter_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_a,
    input  logic [W-1:0] load_r,
    input  logic         accept,
    input  logic         mode_in,
    input  logic         step_en,
    output logic         mode_q,
    output logic [W-1:0] a_q,
    output logic [W-1:0] r_q
);
    logic [W-1:0] a_nx, r_nx;

    // per-bit next values: both halves move right, the boundary bits cross over
    for (genvar i = 0; i < W - 1; i++) begin : g_bits
        assign r_nx[i] = r_q[i+1];
        assign a_nx[i] = a_q[i+1];
    end
    assign r_nx[W-1] = a_q[0];
    assign a_nx[W-1] = (mode_q == MODE_ARITH) ? a_q[W-1] : r_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            r_q    <= '0;
            mode_q <= MODE_ROTATE;
        end else begin
            if (accept) begin
                mode_q <= mode_in;
            end
            if (load) begin
                a_q <= load_a;
                r_q <= load_r;
            end else if (step_en) begin
                a_q <= a_nx;
                r_q <= r_nx;
            end
        end
    end
endmodule

// File: rtl/pair_shifter.sv
module pair_shifter
    import pair_shifter_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [CNT_W-1:0]  count,
    input  logic              load_en,
    input  logic [HALF_W-1:0] load_a,
    input  logic [HALF_W-1:0] load_r,
    output logic [HALF_W-1:0] acc_a,
    output logic [HALF_W-1:0] ext_r,
    output logic              busy,
    output logic              done
);
    logic accept, step_en, last, mode_q, load_ok;

    assign load_ok = load_en && !busy;

    shift_control u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .last    (last),
        .accept  (accept),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    shift_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .init    (count),
        .advance (step_en),
        .last    (last)
    );

    pair_datapath #(.W(HALF_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_ok),
        .load_a  (load_a),
        .load_r  (load_r),
        .accept  (accept),
        .mode_in (mode),
        .step_en (step_en),
        .mode_q  (mode_q),
        .a_q     (acc_a),
        .r_q     (ext_r)
    );
endmodule

// File: rtl/pair_shifter_checker.sv
module pair_shifter_checker
    import pair_shifter_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              step_en,
    input logic              mode_q,
    input logic [HALF_W-1:0] acc_a,
    input logic [HALF_W-1:0] ext_r
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_step_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (ext_r[HALF_W-1] == $past(acc_a[0])));

    assert_rotate_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mode_q == MODE_ROTATE) |=>
            ($countones({acc_a, ext_r}) == $countones($past({acc_a, ext_r}))));

    assert_arith_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && mode_q == MODE_ARITH) |=> (acc_a[HALF_W-1] == $past(acc_a[HALF_W-1])));

    assert_hold_in_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(acc_a) && $stable(ext_r)));
endmodule

bind pair_shifter pair_shifter_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .step_en (step_en),
    .mode_q  (mode_q),
    .acc_a   (acc_a),
    .ext_r   (ext_r)
);

// File: tb/sim_pair_shifter.sv
module sim_pair_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [5:0]  count = '0;
    logic        load_en = 1'b0;
    logic [31:0] load_a = '0;
    logic [31:0] load_r = '0;
    logic [31:0] acc_a, ext_r;
    logic        busy, done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pair_shifter u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count(count),
        .load_en(load_en), .load_a(load_a), .load_r(load_r),
        .acc_a(acc_a), .ext_r(ext_r), .busy(busy), .done(done)
    );

    task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model built from R4, R5, R6, R7
    function automatic logic [63:0] ref_run(logic m, logic [5:0] c, logic [63:0] p);
        logic [63:0] v = p;
        int n = 64 - int'(c);
        for (int k = 0; k < n; k++) begin
            logic top = m ? v[63] : v[0];
            v = {top, v[63:1]};
        end
        return v;
    endfunction

    task automatic do_load(logic [31:0] a, logic [31:0] r);
        @(negedge clk);
        load_en = 1'b1; load_a = a; load_r = r;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // start at a negedge, return the number of negedges until done was seen
    task automatic run(logic m, logic [5:0] c, bit disturb, output int n);
        @(negedge clk);
        start = 1'b1; mode = m; count = c;
        @(negedge clk);
        start = 1'b0; mode = ~m; count = 6'd60;
        n = 1;
        while (!done && n < 200) begin
            if (disturb && n == 3) begin
                load_en = 1'b1; load_a = 32'hFFFF_0000; load_r = 32'h1234_5678;
                start = 1'b1;
            end else begin
                load_en = 1'b0; start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        load_en = 1'b0; start = 1'b0;
    endtask

    task automatic t_reset();
        check64("R1 pair", {acc_a, ext_r}, 64'h0);
        check64("R1 flags", {62'h0, busy, done}, 64'h0);
    endtask

    task automatic t_load();
        do_load(32'hA5A5_0F0F, 32'h0123_4567);
        check64("R2 load", {acc_a, ext_r}, 64'hA5A5_0F0F_0123_4567);
    endtask

    task automatic t_shift(string req, logic m, logic [5:0] c, logic [63:0] p, bit disturb);
        int n;
        do_load(p[63:32], p[31:0]);
        run(m, c, disturb, n);
        check64({req, " result"}, {acc_a, ext_r}, ref_run(m, c, p));
        check64("R7/R8 done cycle", 64'(n), 64'(65 - int'(c)));
        @(negedge clk);
        check64("R8 done single, idle after", {62'h0, busy, done}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_shift("R4 R5 one step rotate", 1'b0, 6'd63, 64'h8000_0001_0000_0001, 1'b0);
        t_shift("R6 one step arith", 1'b1, 6'd63, 64'h8000_0001_0000_0002, 1'b0);
        t_shift("R5 R7 full rotate", 1'b0, 6'd0, 64'hDEAD_BEEF_0BAD_F00D, 1'b0);
        t_shift("R6 R7 full arith neg", 1'b1, 6'd0, 64'h8765_4321_0000_0000, 1'b0);
        t_shift("R6 arith positive 32", 1'b1, 6'd32, 64'h4000_0003_FFFF_0000, 1'b0);
        t_shift("R5 rotate 20", 1'b0, 6'd44, 64'h0000_0001_8000_0000, 1'b0);
        t_shift("R3 R9 disturbed rotate", 1'b0, 6'd40, 64'h0F0F_F0F0_3C3C_C3C3, 1'b1);
        t_shift("R3 R9 disturbed arith", 1'b1, 6'd50, 64'hC000_1111_2222_3333, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule